// File: doc/BRIEF.md
# Single-Cycle Five-Instruction Processor Core

This block is a small processor that completes one instruction on every rising clock edge while its run enable is high. It keeps its program and its data in two separate word-addressed memories of 1024 sixteen-bit words each. Its state is a 10-bit program counter and eight general 16-bit registers. The instruction set has five members: register add, conditional PC-relative branch, load and store with an absolute address, and set-immediate.

A testbench or boot controller fills program memory through a dedicated write port, usually while the core is held in reset. It then raises the run enable and watches progress through the program counter output. Two combinational debug read ports expose any register and any data-memory word. An opcode outside the five assigned values halts the core and raises a sticky flag that only reset clears.

Top module: `t16_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the program counter to 0, every register to 0 and `illegal_o` to 0. The contents of program and data memory are kept across reset.
- R2: Opcode 000 in bits 15-13 (add) writes the sum, truncated to 16 bits, of the registers selected by bits 12-10 and 9-7 into the register selected by bits 6-4. The program counter then increments.
- R3: Opcode 001 (branch) adds the field in bits 9-0 to the program counter modulo 1024 when register 0 holds zero. Otherwise the program counter increments. No register changes.
- R4: Opcode 010 (load) copies the data-memory word at the address in bits 9-0 into the register selected by bits 12-10. The program counter then increments.
- R5: Opcode 011 (store) writes the register selected by bits 12-10 into data memory at the address in bits 9-0. The program counter then increments.
- R6: Opcode 100 (set) zero-extends bits 9-0 to 16 bits and writes the result into the register selected by bits 12-10. The program counter then increments.
- R7: Every non-branch instruction increments the program counter by one, modulo 1024, so 1023 is followed by 0.
- R8: While `run_en` is low, the program counter, the registers, data memory and `illegal_o` keep their values.
- R9: Fetching opcode 101, 110 or 111 with `run_en` high sets `illegal_o` one clock later. From then until reset, the program counter stays put and no register or data-memory word is written.
- R10: A write on the preload port (`pm_we`, `pm_waddr`, `pm_wdata`) stores the word into program memory at that address. The core later fetches and executes it.
- R11: `dbg_reg_data` shows the register selected by `dbg_reg_sel`, and `dbg_dm_data` shows the data-memory word at `dbg_dm_addr`. Both reads are combinational.
- R12: After set R1=3 and set R2=6, the word 0x0530 (add R1+R2 into R3) leaves R3=9. The word 0x6C01 (store R3 at address 1) that follows it leaves data memory word 1 equal to 9. The program counter advances by one per step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Execute one instruction per clock when high |
| pm_we | input | 1 | Program-memory preload write strobe |
| pm_waddr | input | 10 | Program-memory preload address |
| pm_wdata | input | 16 | Program-memory preload data |
| dbg_reg_sel | input | 3 | Register index for the debug read |
| dbg_reg_data | output | 16 | Contents of the selected register |
| dbg_dm_addr | input | 10 | Data-memory address for the debug read |
| dbg_dm_data | output | 16 | Data-memory word at `dbg_dm_addr` |
| pc_o | output | 10 | Current program counter |
| illegal_o | output | 1 | Sticky unassigned-opcode flag |

## Verification
Every architectural effect of an instruction (the new program counter, the register write, the data-memory write and the illegal flag) is due at the first rising edge after the instruction is fetched with `run_en` high. The debug reads follow their select inputs in the same cycle. The bench changes inputs on the falling edge, lets exactly one rising edge pass per step and samples on the next falling edge. It selects each register or memory word one falling edge ahead of the compare, with `run_en` low, so nothing moves while it reads.

// File: rtl/t16_pkg.sv
package t16_pkg;

    localparam int OPW = 3;

    localparam logic [OPW-1:0] OP_ADD = 3'b000;
    localparam logic [OPW-1:0] OP_BR  = 3'b001;
    localparam logic [OPW-1:0] OP_LD  = 3'b010;
    localparam logic [OPW-1:0] OP_ST  = 3'b011;
    localparam logic [OPW-1:0] OP_SET = 3'b100;

    function automatic logic op_legal(input logic [OPW-1:0] op);
        return op <= OP_SET;
    endfunction

endpackage

// File: rtl/t16_ram.sv
// Word-addressed storage: one synchronous write port, NRD combinational reads.
module t16_ram #(
    parameter int AW  = 10,
    parameter int W   = 16,
    parameter int NRD = 1
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata[i] = mem[raddr[i]];
    end
endmodule

// File: rtl/t16_regs.sv
// General register file: cleared by reset, one write port, NRD combinational reads.
module t16_regs #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int NRD  = 4,
    parameter int RSW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [RSW-1:0]          waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][RSW-1:0] raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata[i] = regs_q[raddr[i]];
    end
endmodule

// File: rtl/t16_core.sv
module t16_core #(
    parameter int AW   = 10,
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_en,
    input  logic                     pm_we,
    input  logic [AW-1:0]            pm_waddr,
    input  logic [DW-1:0]            pm_wdata,
    input  logic [$clog2(NREG)-1:0]  dbg_reg_sel,
    output logic [DW-1:0]            dbg_reg_data,
    input  logic [AW-1:0]            dbg_dm_addr,
    output logic [DW-1:0]            dbg_dm_data,
    output logic [AW-1:0]            pc_o,
    output logic                     illegal_o
);
    import t16_pkg::*;

    localparam int RSW   = $clog2(NREG);
    localparam int OP_LO = DW - OPW;
    localparam int RA_LO = OP_LO - RSW;
    localparam int RB_LO = RA_LO - RSW;
    localparam int RC_LO = RB_LO - RSW;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          ill;
    } core_st_t;

    core_st_t st_d, st_q;

    // instruction fetch and field split
    logic [DW-1:0]    ins;
    logic [OPW-1:0]   cur_op;
    logic [RSW-1:0]   f_ra, f_rb, f_rc;
    logic [AW-1:0]    f_imm;
    logic [RC_LO-1:0] unused_lsbs;

    assign cur_op      = ins[DW-1 -: OPW];
    assign f_ra        = ins[OP_LO-1 -: RSW];
    assign f_rb        = ins[RA_LO-1 -: RSW];
    assign f_rc        = ins[RB_LO-1 -: RSW];
    assign f_imm       = ins[AW-1:0];
    assign unused_lsbs = ins[RC_LO-1:0];

    t16_ram #(.AW(AW), .W(DW), .NRD(1)) u_pmem (
        .clk   (clk),
        .we    (pm_we),
        .waddr (pm_waddr),
        .wdata (pm_wdata),
        .raddr (st_q.pc),
        .rdata (ins)
    );

    // register file: port 0 = ra, 1 = rb, 2 = debug, 3 = register 0
    logic [3:0][DW-1:0] rf_rdata;
    logic [DW-1:0]      ra_val, rb_val, r0_val;
    logic               rf_we;
    logic [RSW-1:0]     rf_wa;
    logic [DW-1:0]      rf_wd;

    t16_regs #(.DW(DW), .NREG(NREG), .NRD(4), .RSW(RSW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_wa),
        .wdata (rf_wd),
        .raddr ({RSW'(0), dbg_reg_sel, f_rb, f_ra}),
        .rdata (rf_rdata)
    );

    assign ra_val       = rf_rdata[0];
    assign rb_val       = rf_rdata[1];
    assign dbg_reg_data = rf_rdata[2];
    assign r0_val       = rf_rdata[3];

    // data memory: port 0 = execute, 1 = debug
    logic [1:0][DW-1:0] dm_rdata;
    logic [DW-1:0]      dm_rd;
    logic               dm_we;

    t16_ram #(.AW(AW), .W(DW), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    (dm_we && !rst),
        .waddr (f_imm),
        .wdata (ra_val),
        .raddr ({dbg_dm_addr, f_imm}),
        .rdata (dm_rdata)
    );

    assign dm_rd       = dm_rdata[0];
    assign dbg_dm_data = dm_rdata[1];

    // next-state logic
    logic [AW-1:0] pc_inc;
    assign pc_inc = st_q.pc + AW'(1);

    always_comb begin
        st_d  = st_q;
        rf_we = 1'b0;
        rf_wa = f_ra;
        rf_wd = dm_rd;
        dm_we = 1'b0;
        if (run_en && !st_q.ill) begin
            case (cur_op)
                OP_ADD: begin
                    rf_we    = 1'b1;
                    rf_wa    = f_rc;
                    rf_wd    = ra_val + rb_val;
                    st_d.pc  = pc_inc;
                end
                OP_BR: begin
                    st_d.pc = (r0_val == '0) ? st_q.pc + f_imm : pc_inc;
                end
                OP_LD: begin
                    rf_we   = 1'b1;
                    st_d.pc = pc_inc;
                end
                OP_ST: begin
                    dm_we   = 1'b1;
                    st_d.pc = pc_inc;
                end
                OP_SET: begin
                    rf_we   = 1'b1;
                    rf_wd   = DW'(f_imm);
                    st_d.pc = pc_inc;
                end
                default: begin
                    st_d.ill = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign illegal_o = st_q.ill;
endmodule

// File: rtl/t16_core_chk.sv
module t16_core_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          run_en,
    input logic [AW-1:0] pc,
    input logic          ill,
    input logic [2:0]    op
);
    import t16_pkg::*;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0) && !ill);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(pc) && $stable(ill));

    // R9
    ill_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ill |=> ill);

    // R9
    ill_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ill |=> $stable(pc));

    // R9
    ill_catch_chk: assert property (@(posedge clk) disable iff (rst)
        run_en && !ill && !op_legal(op) |=> ill && $stable(pc));

    // R7
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        run_en && !ill && op_legal(op) && (op != OP_BR) |=> pc == $past(pc) + AW'(1));
endmodule

bind t16_core t16_core_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .pc     (pc_o),
    .ill    (illegal_o),
    .op     (cur_op)
);

// File: tb/t16_core_bench.sv
module t16_core_bench;
    localparam int AW    = 10;
    localparam int DW    = 16;
    localparam int NREG  = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1, run_en = 1'b0, pm_we = 1'b0;
    logic [AW-1:0] pm_waddr = '0, dbg_dm_addr = '0;
    logic [DW-1:0] pm_wdata = '0;
    logic [2:0]    dbg_reg_sel = '0;
    logic [DW-1:0] dbg_reg_data, dbg_dm_data;
    logic [AW-1:0] pc_o;
    logic          illegal_o;

    t16_core u_t16_core (
        .clk(clk), .rst(rst), .run_en(run_en),
        .pm_we(pm_we), .pm_waddr(pm_waddr), .pm_wdata(pm_wdata),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
        .dbg_dm_addr(dbg_dm_addr), .dbg_dm_data(dbg_dm_data),
        .pc_o(pc_o), .illegal_o(illegal_o)
    );

    int n_chk = 0, n_err = 0;

    logic [DW-1:0] pm_img [DEPTH];
    logic [DW-1:0] m_reg  [NREG];
    logic [DW-1:0] m_dm   [DEPTH];
    logic [AW-1:0] m_pc;
    logic          m_ill;

    // instruction builders (field layout per R2..R6)
    function automatic logic [15:0] i_add(input int a, input int b, input int c);
        return {3'b000, 3'(a), 3'(b), 3'(c), 4'b0000};
    endfunction
    function automatic logic [15:0] i_br(input int off);
        return {3'b001, 3'b000, 10'(off)};
    endfunction
    function automatic logic [15:0] i_ld(input int r, input int ad);
        return {3'b010, 3'(r), 10'(ad)};
    endfunction
    function automatic logic [15:0] i_st(input int r, input int ad);
        return {3'b011, 3'(r), 10'(ad)};
    endfunction
    function automatic logic [15:0] i_set(input int r, input int k);
        return {3'b100, 3'(r), 10'(k)};
    endfunction

    function automatic logic [15:0] rnd_ins();
        int unsigned k = $urandom_range(0, 9);
        int a = int'($urandom_range(0, 7));
        int b = int'($urandom_range(0, 7));
        int c = int'($urandom_range(0, 7));
        if (k < 3)  return i_add(a, b, c);
        if (k == 3) return i_br(int'($urandom_range(0, 1023)));
        if (k < 6)  return i_ld(a, b);
        if (k < 8)  return i_st(a, b);
        if (k == 8) return i_set(0, 0);
        return i_set(a, int'($urandom_range(0, 1023)));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc  = '0;
        m_ill = 1'b0;
        for (int k = 0; k < NREG; k++) m_reg[k] = '0;
    endtask

    // reference step computed from the requirements
    task automatic ref_step(output string tag, output logic st_done, output logic [AW-1:0] st_addr);
        logic [15:0] w;
        logic [2:0]  op, ra, rb, rc;
        logic [9:0]  imm;
        w = pm_img[m_pc];
        op = w[15:13]; ra = w[12:10]; rb = w[9:7]; rc = w[6:4]; imm = w[9:0];
        st_done = 1'b0;
        st_addr = imm;
        tag = "R9";
        if (m_ill) return;
        case (op)
            3'b000: begin m_reg[rc] = m_reg[ra] + m_reg[rb]; m_pc = m_pc + 1'b1; tag = "R2"; end
            3'b001: begin m_pc = (m_reg[0] == '0) ? m_pc + imm : m_pc + 1'b1; tag = "R3"; end
            3'b010: begin m_reg[ra] = m_dm[imm]; m_pc = m_pc + 1'b1; tag = "R4"; end
            3'b011: begin m_dm[imm] = m_reg[ra]; m_pc = m_pc + 1'b1; st_done = 1'b1; tag = "R5"; end
            3'b100: begin m_reg[ra] = {6'b0, imm}; m_pc = m_pc + 1'b1; tag = "R6"; end
            default: m_ill = 1'b1;
        endcase
    endtask

    task automatic rd_reg(input int k, output logic [DW-1:0] v);
        dbg_reg_sel = 3'(k);
        @(negedge clk);
        v = dbg_reg_data;
    endtask

    task automatic rd_dm(input int ad, output logic [DW-1:0] v);
        dbg_dm_addr = AW'(ad);
        @(negedge clk);
        v = dbg_dm_data;
    endtask

    task automatic check_all(input string tag, input logic st_done, input logic [AW-1:0] st_addr);
        logic [DW-1:0] v;
        chk({tag, " pc"}, 32'(pc_o), 32'(m_pc));
        chk({tag, " illegal"}, 32'(illegal_o), 32'(m_ill));
        for (int k = 0; k < NREG; k++) begin
            rd_reg(k, v);
            chk({tag, " R11 reg"}, 32'(v), 32'(m_reg[k]));
        end
        if (st_done) begin
            rd_dm(int'(st_addr), v);
            chk({tag, " R11 dm"}, 32'(v), 32'(m_dm[st_addr]));
        end
    endtask

    task automatic step();
        string tag;
        logic sd;
        logic [AW-1:0] sa;
        ref_step(tag, sd, sa);
        run_en = 1'b1;
        @(negedge clk);
        run_en = 1'b0;
        check_all(tag, sd, sa);
    endtask

    task automatic step_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // R10: fill program memory through the preload port while in reset
    task automatic boot();
        rst = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            pm_we = 1'b1; pm_waddr = AW'(a); pm_wdata = pm_img[a];
            @(negedge clk);
        end
        pm_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic fill_pm(input logic [15:0] w);
        for (int a = 0; a < DEPTH; a++) pm_img[a] = w;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] v;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);

        // ---- R1 reset state ----
        fill_pm(i_set(0, 0));
        boot();
        check_all("R1 reset", 1'b0, '0);

        // ---- directed program: R12, R2..R8 ----
        fill_pm(i_set(7, 0));
        pm_img[0] = i_st(0, 1);
        pm_img[1] = i_set(1, 3);
        pm_img[2] = i_set(2, 6);
        pm_img[3] = 16'h0530;
        pm_img[4] = 16'h6C01;
        pm_img[5] = i_ld(4, 1);
        pm_img[6] = i_set(5, 10'h3FF);
        for (int a = 7; a < 14; a++) pm_img[a] = i_add(5, 5, 5);
        pm_img[14] = i_br(3);
        pm_img[17] = i_set(0, 42);
        pm_img[18] = i_br(100);
        pm_img[19] = i_set(0, 0);
        pm_img[20] = i_br(1003);
        pm_img[1023] = i_set(6, 10'h155);
        boot();
        step_n(4);
        rd_reg(3, v);
        chk("R12 add R1+R2 into R3", 32'(v), 32'd9);
        chk("R12 pc after add", 32'(pc_o), 32'd4);
        repeat (5) @(negedge clk);
        chk("R8 pc held with run_en low", 32'(pc_o), 32'd4);
        rd_dm(1, v);
        chk("R8 store withheld with run_en low", 32'(v), 32'd0);
        step();
        rd_dm(1, v);
        chk("R12 R5 store R3 to word 1", 32'(v), 32'd9);
        step();
        rd_reg(4, v);
        chk("R4 load from word 1", 32'(v), 32'd9);
        step();
        rd_reg(5, v);
        chk("R6 set zero-extends 0x3FF", 32'(v), 32'h0000_03FF);
        step_n(7);
        rd_reg(5, v);
        chk("R2 add truncates to 16 bits", 32'(v), 32'h0000_FF80);
        step();
        chk("R3 branch taken when R0 zero", 32'(pc_o), 32'd17);
        step_n(2);
        chk("R3 branch not taken when R0 nonzero", 32'(pc_o), 32'd19);
        step_n(2);
        chk("R3 branch wraps modulo 1024", 32'(pc_o), 32'd1023);
        step();
        chk("R7 pc wraps 1023 to 0", 32'(pc_o), 32'd0);
        rd_reg(6, v);
        chk("R6 set at top address", 32'(v), 32'h0000_0155);
        do_reset();
        check_all("R1 reset after run", 1'b0, '0);
        rd_dm(1, v);
        chk("R1 data memory kept over reset", 32'(v), 32'd9);
        step();
        rd_dm(1, v);
        chk("R10 program kept over reset", 32'(v), 32'd0);

        // ---- R9 unassigned opcodes ----
        for (int op = 5; op < 8; op++) begin
            fill_pm(i_set(7, 0));
            pm_img[0] = i_st(0, 3);
            pm_img[1] = i_set(1, 16'h11);
            pm_img[2] = {3'(op), 3'd1, 10'd3};
            pm_img[3] = i_set(2, 5);
            boot();
            step_n(3);
            chk("R9 illegal flag set", 32'(illegal_o), 32'd1);
            chk("R9 pc stops at bad word", 32'(pc_o), 32'd2);
            step_n(3);
            rd_dm(3, v);
            chk("R9 no memory write while halted", 32'(v), 32'd0);
            rd_reg(2, v);
            chk("R9 no register write while halted", 32'(v), 32'd0);
            do_reset();
            chk("R1 R9 reset clears illegal flag", 32'(illegal_o), 32'd0);
            step_n(2);
            rd_reg(1, v);
            chk("R9 runs again after reset", 32'(v), 32'h11);
        end

        // ---- constrained random programs ----
        for (int round = 0; round < 3; round++) begin
            for (int a = 0; a < DEPTH; a++) pm_img[a] = rnd_ins();
            for (int a = 0; a < 8; a++) pm_img[a] = i_st(0, a);
            boot();
            step_n(300);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule